// File: doc/BRIEF.md
# Configuration retry-status completion handler

This block sits in a root port between the host's configuration-access port and the link's completion path. It takes one host configuration request at a time, sends it toward the link and watches the completion status that comes back. A completion that asks for a retry is dealt with here, so the host never sees it. The block either sends the same request again as a new request, or it answers the host directly with a made-up read value.

A software-visibility enable picks between the two. When the enable is clear, every retry leads to another request. When it is set, a read covering both bytes of the identifier field at register offset 0 is answered at once with the value 0x0001. Every other retry case, writes included, is sent again. A programmable cap on the number of loops stops a target that never settles: when the cap is reached, the request ends as a failed transaction. An unsupported or aborted completion also fails the request at once.

Top module: `cfg_retry_resolver`

## Requirements
- R1: With `swVisEn` low, every completion with status retry (`linkCplStatus` = 2'b01) causes the same request to be issued again on the link (`linkIssueValid` pulse with the same write flag, offset, byte enables and write data), unless the cap in R6 has been reached.
- R2: With `swVisEn` high, a retry on a read at byte offset 0 whose byte enables [1:0] are both set ends the request without a further issue. The response has `hostRspError` low and bits [15:0] of `hostRspData` equal to 16'h0001.
- R3: In the response of R2, each upper byte (bits [23:16] and [31:24]) reads 8'hFF when its byte enable is set and 8'h00 when it is clear.
- R4: With `swVisEn` high, a write that receives a retry is issued again, not completed.
- R5: With `swVisEn` high, a read that does not cover both identifier bytes (offset not 0, or byte enable 0 or 1 clear) is issued again on a retry.
- R6: With `retryLimit` = L > 0, the L-th retry completion of a request ends it as failed: `hostRspError` high and `hostRspData` all ones. L issues are made in total.
- R7: With `retryLimit` = 0, retries never end a request. The loop count starts from zero for each new host request.
- R8: A successful completion (`linkCplStatus` = 2'b00) returns `linkCplData` unchanged with `hostRspError` low. Every response carries the request's byte enables on `hostRspByteEn`.
- R9: An unsupported/abort completion (`linkCplStatus` = 2'b10 or 2'b11) fails the request at once: all-ones data, error high, no further issue.
- R10: Only one request is outstanding. `hostReqReady` is low from acceptance until the response. `hostRspValid` is a one-cycle pulse, and `hostReqReady` is high again in the cycle after it. `hostReqReady` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swVisEn | input | 1 | Software-visibility enable for retry status |
| retryLimit | input | LIMIT_W | Retry cap, 0 means unlimited |
| hostReqValid | input | 1 | Host request valid |
| hostReqReady | output | 1 | Block can accept a request |
| hostReqWrite | input | 1 | 1 = configuration write |
| hostReqOffset | input | OFF_W | Byte offset of the dword register |
| hostReqByteEn | input | 4 | Byte enables |
| hostReqWrData | input | 32 | Write data |
| hostRspValid | output | 1 | One-cycle response strobe |
| hostRspData | output | 32 | Response read data |
| hostRspByteEn | output | 4 | Byte enables of the answered request |
| hostRspError | output | 1 | Request failed |
| linkIssueValid | output | 1 | One-cycle request issue strobe |
| linkIssueWrite | output | 1 | Issued write flag |
| linkIssueOffset | output | OFF_W | Issued offset |
| linkIssueByteEn | output | 4 | Issued byte enables |
| linkIssueWrData | output | 32 | Issued write data |
| linkCplValid | input | 1 | Completion strobe |
| linkCplStatus | input | 2 | 00 success, 01 retry, 10/11 unsupported/abort |
| linkCplData | input | 32 | Completion read data |

## Verification
Two outcomes can be decided by the same retry completion. One is the synthesized identifier answer. The other is the cap reaching its limit, and it also occurs when a write or a non-covering read hits the cap on the very retry that would otherwise loop. The bench sets up this collision with a cap of 1 on identifier reads with visibility both on and off. With visibility on, the answer must be the synthesized value. With it off, it must be a failure with one issue. Randomly chosen requests mix caps, retry counts and final statuses. Each response is compared against a bench function that predicts the data, the error flag and the number of issues.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
  typedef enum logic [1:0] {
    CPL_OK    = 2'b00,
    CPL_RETRY = 2'b01,
    CPL_ABORT = 2'b10
  } cplStatus_t;

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_SYNTH = 2'd1,
    SEL_FAIL  = 2'd2
  } rspSel_t;

  typedef struct packed {
    logic    capture;
    logic    bumpCnt;
    logic    loadRsp;
    rspSel_t rspSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfg_retry_dp.sv
module cfg_retry_dp
  import cfg_retry_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [LIMIT_W-1:0] retryLimit,
  input  logic               hostReqWrite,
  input  logic [OFF_W-1:0]   hostReqOffset,
  input  logic [3:0]         hostReqByteEn,
  input  logic [31:0]        hostReqWrData,
  input  logic [31:0]        linkCplData,
  output logic               vidCovered,
  output logic               limitHit,
  output logic               reqWrite,
  output logic [OFF_W-1:0]   reqOffset,
  output logic [3:0]         reqByteEn,
  output logic [31:0]        reqWrData,
  output logic [31:0]        hostRspData,
  output logic               hostRspError
);
  localparam int CNT_W = LIMIT_W + 1;

  logic [LIMIT_W-1:0] retryCnt;
  logic [CNT_W-1:0]   nextCnt;
  logic [31:0]        synthData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWrite  <= 1'b0;
      reqOffset <= '0;
      reqByteEn <= '0;
      reqWrData <= '0;
      retryCnt  <= '0;
    end else if (strb.capture) begin
      reqWrite  <= hostReqWrite;
      reqOffset <= hostReqOffset;
      reqByteEn <= hostReqByteEn;
      reqWrData <= hostReqWrData;
      retryCnt  <= '0;
    end else if (strb.bumpCnt) begin
      retryCnt <= retryCnt + 1'b1;
    end
  end

  assign nextCnt    = {1'b0, retryCnt} + 1'b1;
  assign limitHit   = (retryLimit != '0) && (nextCnt >= {1'b0, retryLimit});
  assign vidCovered = !reqWrite && (reqOffset == '0) && (reqByteEn[1:0] == 2'b11);

  // low half carries the reserved identifier, upper enabled bytes read as ones
  assign synthData[15:0] = 16'h0001;
  for (genvar b = 2; b < 4; b++) begin : g_synthByte
    assign synthData[8*b +: 8] = reqByteEn[b] ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRspData  <= '0;
      hostRspError <= 1'b0;
    end else if (strb.loadRsp) begin
      unique case (strb.rspSel)
        SEL_PASS:  begin hostRspData <= linkCplData; hostRspError <= 1'b0; end
        SEL_SYNTH: begin hostRspData <= synthData;   hostRspError <= 1'b0; end
        default:   begin hostRspData <= '1;          hostRspError <= 1'b1; end
      endcase
    end
  end

  assert_synth_vid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRsp && strb.rspSel == SEL_SYNTH) |=> (hostRspData[15:0] == 16'h0001 && !hostRspError));

  assert_synth_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRsp && strb.rspSel == SEL_SYNTH && reqByteEn[3]) |=> (hostRspData[31:24] == 8'hFF));

  assert_fail_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRsp && strb.rspSel == SEL_FAIL) |=> (hostRspData == 32'hFFFF_FFFF && hostRspError));
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
  import cfg_retry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         swVisEn,
  input  logic         hostReqValid,
  input  logic         linkCplValid,
  input  logic [1:0]   linkCplStatus,
  input  logic         vidCovered,
  input  logic         limitHit,
  output logic         hostReqReady,
  output logic         hostRspValid,
  output logic         linkIssueValid,
  output ctrlStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strb        = '0;
    strb.rspSel = SEL_PASS;
    unique case (state)
      ST_IDLE: if (hostReqValid) begin
        strb.capture = 1'b1;
        stateNext    = ST_ISSUE;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: if (linkCplValid) begin
        if (linkCplStatus == CPL_OK) begin
          strb.loadRsp = 1'b1;
          stateNext    = ST_RESP;
        end else if (linkCplStatus == CPL_RETRY) begin
          if (swVisEn && vidCovered) begin
            strb.loadRsp = 1'b1;
            strb.rspSel  = SEL_SYNTH;
            stateNext    = ST_RESP;
          end else if (limitHit) begin
            strb.loadRsp = 1'b1;
            strb.rspSel  = SEL_FAIL;
            stateNext    = ST_RESP;
          end else begin
            strb.bumpCnt = 1'b1;
            stateNext    = ST_ISSUE;
          end
        end else begin
          strb.loadRsp = 1'b1;
          strb.rspSel  = SEL_FAIL;
          stateNext    = ST_RESP;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostReqReady   = (state == ST_IDLE);
  assign linkIssueValid = (state == ST_ISSUE);
  assign hostRspValid   = (state == ST_RESP);

  assert_reissue_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && linkCplValid && linkCplStatus == CPL_RETRY && !swVisEn && !limitHit)
      |=> linkIssueValid);

  assert_abort_no_reissue_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && linkCplValid && linkCplStatus[1]) |=> (!linkIssueValid && hostRspValid));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostReqReady |-> (!linkIssueValid && !hostRspValid));

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostRspValid |=> (!hostRspValid && hostReqReady));
endmodule

// File: rtl/cfg_retry_resolver.sv
module cfg_retry_resolver
  import cfg_retry_pkg::*;
#(
  parameter int OFF_W   = 12,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swVisEn,
  input  logic [LIMIT_W-1:0] retryLimit,
  input  logic               hostReqValid,
  output logic               hostReqReady,
  input  logic               hostReqWrite,
  input  logic [OFF_W-1:0]   hostReqOffset,
  input  logic [3:0]         hostReqByteEn,
  input  logic [31:0]        hostReqWrData,
  output logic               hostRspValid,
  output logic [31:0]        hostRspData,
  output logic [3:0]         hostRspByteEn,
  output logic               hostRspError,
  output logic               linkIssueValid,
  output logic               linkIssueWrite,
  output logic [OFF_W-1:0]   linkIssueOffset,
  output logic [3:0]         linkIssueByteEn,
  output logic [31:0]        linkIssueWrData,
  input  logic               linkCplValid,
  input  logic [1:0]         linkCplStatus,
  input  logic [31:0]        linkCplData
);
  ctrlStrobes_t strb;
  logic vidCovered, limitHit;

  cfg_retry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swVisEn(swVisEn), .hostReqValid(hostReqValid),
    .linkCplValid(linkCplValid), .linkCplStatus(linkCplStatus),
    .vidCovered(vidCovered), .limitHit(limitHit),
    .hostReqReady(hostReqReady), .hostRspValid(hostRspValid),
    .linkIssueValid(linkIssueValid), .strb(strb)
  );

  cfg_retry_dp #(.OFF_W(OFF_W), .LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .retryLimit(retryLimit),
    .hostReqWrite(hostReqWrite), .hostReqOffset(hostReqOffset),
    .hostReqByteEn(hostReqByteEn), .hostReqWrData(hostReqWrData),
    .linkCplData(linkCplData), .vidCovered(vidCovered), .limitHit(limitHit),
    .reqWrite(linkIssueWrite), .reqOffset(linkIssueOffset),
    .reqByteEn(linkIssueByteEn), .reqWrData(linkIssueWrData),
    .hostRspData(hostRspData), .hostRspError(hostRspError)
  );

  assign hostRspByteEn = linkIssueByteEn;
endmodule

// File: tb/cfg_retry_resolver_bench.sv
module cfg_retry_resolver_bench;
  localparam int OFF_W = 12;
  localparam int LIMIT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swVisEn = 1'b0;
  logic [LIMIT_W-1:0] retryLimit = '0;
  logic hostReqValid = 1'b0, hostReqWrite = 1'b0;
  logic [OFF_W-1:0] hostReqOffset = '0;
  logic [3:0] hostReqByteEn = '0;
  logic [31:0] hostReqWrData = '0;
  logic hostReqReady, hostRspValid, hostRspError;
  logic [31:0] hostRspData;
  logic [3:0] hostRspByteEn;
  logic linkIssueValid, linkIssueWrite;
  logic [OFF_W-1:0] linkIssueOffset;
  logic [3:0] linkIssueByteEn;
  logic [31:0] linkIssueWrData;
  logic linkCplValid = 1'b0;
  logic [1:0] linkCplStatus = 2'b00;
  logic [31:0] linkCplData = '0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfg_retry_resolver #(.OFF_W(OFF_W), .LIMIT_W(LIMIT_W)) u_cfg_retry_resolver (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit isSynth(bit sv, bit wr, logic [OFF_W-1:0] off, logic [3:0] be);
    return sv && !wr && off == '0 && be[1:0] == 2'b11;
  endfunction

  function automatic logic [31:0] synthVal(logic [3:0] be);
    return {be[3] ? 8'hFF : 8'h00, be[2] ? 8'hFF : 8'h00, 16'h0001};
  endfunction

  // returns {issues, err, data}
  function automatic logic [63:0] predict(bit sv, int lim, bit wr, logic [OFF_W-1:0] off,
                                          logic [3:0] be, int nRetry, logic [1:0] fin, logic [31:0] d);
    if (nRetry > 0 && isSynth(sv, wr, off, be)) return {16'd1, 16'd0, synthVal(be)};
    if (lim != 0 && nRetry >= lim) return {lim[15:0], 16'd1, 32'hFFFF_FFFF};
    if (fin == 2'b00) return {16'(nRetry + 1), 16'd0, d};
    return {16'(nRetry + 1), 16'd1, 32'hFFFF_FFFF};
  endfunction

  task automatic runReq(input string tag, input bit sv, input int lim, input bit wr,
                        input logic [OFF_W-1:0] off, input logic [3:0] be, input logic [31:0] wd,
                        input int nRetry, input logic [1:0] fin, input logic [31:0] cd);
    int issues = 0;
    int cyc = 0;
    bit seen = 0, readyBad = 0, echoBad = 0;
    logic [31:0] gotData = '0;
    logic gotErr = 1'b0;
    logic [3:0] gotBe = '0;
    logic [63:0] exp;
    @(negedge clk);
    swVisEn = sv; retryLimit = LIMIT_W'(lim);
    hostReqValid = 1'b1; hostReqWrite = wr; hostReqOffset = off;
    hostReqByteEn = be; hostReqWrData = wd;
    @(negedge clk);
    hostReqValid = 1'b0;
    while (!seen && cyc < 4000) begin
      cyc++;
      if (hostRspValid) begin
        seen = 1; gotData = hostRspData; gotErr = hostRspError; gotBe = hostRspByteEn;
      end else begin
        if (hostReqReady) readyBad = 1;
        if (linkIssueValid) begin
          issues++;
          if (linkIssueWrite != wr || linkIssueOffset != off || linkIssueByteEn != be ||
              linkIssueWrData != wd) echoBad = 1;
          @(negedge clk);
          linkCplValid = 1'b1;
          linkCplStatus = (issues <= nRetry) ? 2'b01 : fin;
          linkCplData = cd;
          @(negedge clk);
          linkCplValid = 1'b0;
        end else @(negedge clk);
      end
    end
    exp = predict(sv, lim, wr, off, be, nRetry, fin, cd);
    check(seen && gotData == exp[31:0], {tag, " data"}, gotData, exp[31:0]);
    check(gotErr == exp[32], {tag, " error"}, gotErr, exp[32]);
    check(issues == int'(exp[63:48]), {tag, " issue count"}, issues, exp[63:48]);
    check(gotBe == be, {tag, " byte enables R8"}, gotBe, be);
    check(!echoBad, {tag, " reissued request matches R1"}, echoBad, 0);
    check(!readyBad, {tag, " ready low while busy R10"}, readyBad, 0);
    @(negedge clk);
    check(!hostRspValid && hostReqReady, {tag, " response pulse R10"},
          {hostRspValid, hostReqReady}, 2'b01);
  endtask

  initial begin
    #(5ns * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(hostReqReady && !hostRspValid && !linkIssueValid, "reset state R10",
          {hostReqReady, hostRspValid, linkIssueValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    runReq("R1 vis off id read", 0, 0, 0, 12'h000, 4'hF, 0, 3, 2'b00, 32'h1234_5678);
    runReq("R2 vis on id read", 1, 0, 0, 12'h000, 4'hF, 0, 2, 2'b00, 32'hDEAD_BEEF);
    runReq("R3 low half only", 1, 0, 0, 12'h000, 4'h3, 0, 1, 2'b00, 32'h0);
    runReq("R3 byte2 set", 1, 0, 0, 12'h000, 4'h7, 0, 1, 2'b00, 32'h0);
    runReq("R3 byte3 set", 1, 0, 0, 12'h000, 4'hB, 0, 1, 2'b00, 32'h0);
    runReq("R4 vis on write", 1, 0, 1, 12'h000, 4'hF, 32'hA5A5_0F0F, 2, 2'b00, 32'h0);
    runReq("R5 partial id", 1, 0, 0, 12'h000, 4'h1, 0, 2, 2'b00, 32'h0000_1111);
    runReq("R5 other offset", 1, 0, 0, 12'h004, 4'hF, 0, 3, 2'b00, 32'h2222_3333);
    runReq("R6 cap reached", 0, 3, 0, 12'h010, 4'hF, 0, 5, 2'b00, 32'h0);
    runReq("R6 cap one vis off", 0, 1, 0, 12'h000, 4'hF, 0, 1, 2'b00, 32'h0);
    runReq("R2 cap one vis on", 1, 1, 0, 12'h000, 4'hF, 0, 1, 2'b00, 32'h0);
    runReq("R6 write hits cap", 1, 2, 1, 12'h000, 4'hF, 32'h5, 4, 2'b00, 32'h0);
    runReq("R7 unlimited", 0, 0, 0, 12'h020, 4'hF, 0, 20, 2'b00, 32'hCAFE_F00D);
    runReq("R7 count restarts a", 0, 3, 0, 12'h024, 4'hF, 0, 2, 2'b00, 32'h1);
    runReq("R7 count restarts b", 0, 3, 0, 12'h028, 4'hF, 0, 2, 2'b00, 32'h2);
    runReq("R8 pass through", 1, 4, 0, 12'h008, 4'h6, 0, 0, 2'b00, 32'h0BAD_C0DE);
    runReq("R9 abort", 0, 0, 0, 12'h00C, 4'hF, 0, 0, 2'b10, 32'h0);
    runReq("R9 abort after retry", 0, 0, 0, 12'h00C, 4'hF, 0, 2, 2'b11, 32'h0);
    for (int i = 0; i < 40; i++) begin
      automatic bit sv = 1'($urandom_range(0, 1));
      automatic int lim = $urandom_range(0, 4);
      automatic bit wr = 1'($urandom_range(0, 3) == 0);
      automatic logic [OFF_W-1:0] off = ($urandom_range(0, 1) == 0) ? '0 : OFF_W'($urandom_range(1, 63) * 4);
      automatic logic [3:0] be = 4'($urandom_range(1, 15));
      automatic int nr = $urandom_range(0, 6);
      automatic logic [1:0] fin = ($urandom_range(0, 3) == 0) ? 2'b10 : 2'b00;
      runReq("R1 R5 R6 random", sv, lim, wr, off, be, $urandom, nr, fin, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule